// File: doc/BRIEF.md
# Uncached L2 Memory Window Decoder

This block sits in front of the on-chip L2 storage and decides whether a request falling in a fixed 2 MiB address window may reach that storage as plain, deterministic memory. The window is cut into sixteen 128 KiB slots, one for each cache way. Software grows the cache by raising a way-enable index. Every way at or below that index belongs to the cache and is closed to the window. Every way above it stays reachable as ordinary memory. A way is always one or the other, never both.

For each valid request the decoder reports one of three results: the address is outside the window and not claimed, the access is accepted, or the access is refused. For an accepted access it also returns the way number and the byte offset inside that way, which drive the storage array. A refused access gets an error response and makes no array access. The decode is registered, so every response arrives exactly one clock after its request, whatever the address.

Top module: `lim_window_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, all outputs are zero.
- R2: Each response appears exactly one clock edge after the request that caused it, with the same latency for every address.
- R3: A request whose address bits [31:21] differ from the window base 0x0800_0000 (for example 0x07FF_FFFF or 0x0820_0000) gives `rsp_claim`, `rsp_hit` and `rsp_err` all zero.
- R4: A request in the window whose way number, address bits [20:17], is greater than `way_en_idx` gives `rsp_hit`=1, `rsp_err`=0, `rsp_way` equal to bits [20:17] and `rsp_offset` equal to bits [16:0].
- R5: A request in the window whose way number is less than or equal to `way_en_idx` gives `rsp_err`=1, `rsp_hit`=0, and `rsp_way` and `rsp_offset` both zero, so the array is not addressed.
- R6: When `req_valid` is low, the next response has every output zero, whatever the address.
- R7: `rsp_hit` and `rsp_err` are never high together, and `rsp_claim` is high exactly when one of them is high.
- R8: With `way_en_idx`=0, ways 1 to 15 (1920 KiB) are reachable and way 0 is refused. With `way_en_idx`=15, the whole window is refused. Each increment of the index closes exactly one more 128 KiB way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| way_en_idx | input | 4 | Index of the highest way given to the cache |
| rsp_claim | output | 1 | Request fell inside the window |
| rsp_hit | output | 1 | Access accepted; drive the array |
| rsp_err | output | 1 | Access refused; error response |
| rsp_way | output | 4 | Selected way, zero unless accepted |
| rsp_offset | output | 17 | Byte offset in the way, zero unless accepted |

## Verification
The assertions check on every cycle that accept and refuse exclude each other and together make up the claim. They also check that no response follows an idle cycle, that an accepted way lies strictly above the previous cycle's way-enable index, that every claim came from an address inside the window, and that refused or idle responses carry a zero way and offset. Only the bench scenarios show the exact way and offset values, the boundary between ways at each way-enable setting, the edges of the window, and the reset state. They also show that the window shrinks by exactly one way each time the index rises.

// File: rtl/lim_window_decoder.sv
module lim_window_decoder #(
  parameter int                ADDR_W    = 32,
  parameter int                WAY_W     = 4,
  parameter int                OFFSET_W  = 17,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0800_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WAY_W-1:0]    way_en_idx,
  output logic                rsp_claim,
  output logic                rsp_hit,
  output logic                rsp_err,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [OFFSET_W-1:0] rsp_offset
);
  localparam int WIN_LSB = WAY_W + OFFSET_W;
  localparam int TAG_W   = ADDR_W - WIN_LSB;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_LSB];

  logic             in_win;
  logic             mem_way;
  logic [WAY_W-1:0] way_sel;

  assign in_win  = req_valid && (req_addr[ADDR_W-1:WIN_LSB] == BASE_TAG);
  assign way_sel = req_addr[WIN_LSB-1:OFFSET_W];
  assign mem_way = way_sel > way_en_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_claim  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_way    <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_claim  <= in_win;
      rsp_hit    <= in_win && mem_way;
      rsp_err    <= in_win && !mem_way;
      rsp_way    <= (in_win && mem_way) ? way_sel : '0;
      rsp_offset <= (in_win && mem_way) ? req_addr[OFFSET_W-1:0] : '0;
    end
  end
endmodule

module lim_window_decoder_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                WAY_W     = 4,
  parameter int                OFFSET_W  = 17,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0800_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [WAY_W-1:0]    way_en_idx,
  input logic                rsp_claim,
  input logic                rsp_hit,
  input logic                rsp_err,
  input logic [WAY_W-1:0]    rsp_way,
  input logic [OFFSET_W-1:0] rsp_offset
);
  localparam int WIN_LSB = WAY_W + OFFSET_W;

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_err));
  p_claim_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_claim == (rsp_hit || rsp_err));
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !rsp_claim);
  p_way_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_way > $past(way_en_idx));
  p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_claim |-> $past(req_addr[ADDR_W-1:WIN_LSB]) == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  p_no_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_way == '0 && rsp_offset == '0));
endmodule

bind lim_window_decoder lim_window_decoder_chk #(
  .ADDR_W(ADDR_W), .WAY_W(WAY_W), .OFFSET_W(OFFSET_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/lim_window_decoder_tb.sv
module lim_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  way_en_idx = '0;
  logic        rsp_claim, rsp_hit, rsp_err;
  logic [3:0]  rsp_way;
  logic [16:0] rsp_offset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lim_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .way_en_idx(way_en_idx), .rsp_claim(rsp_claim), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_offset(rsp_offset)
  );

  function automatic logic [23:0] model(input logic v, input logic [31:0] a,
                                        input logic [3:0] en);
    logic win;
    logic ok;
    win = v && (a[31:21] == 11'h040);
    ok  = a[20:17] > en;
    if (!win)     return 24'h0;
    else if (ok)  return {1'b1, 1'b1, 1'b0, a[20:17], a[16:0]};
    else          return {1'b1, 1'b0, 1'b1, 4'h0, 17'h0};
  endfunction

  task automatic check(input string tag, input logic [23:0] exp);
    logic [23:0] act;
    act = {rsp_claim, rsp_hit, rsp_err, rsp_way, rsp_offset};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] a, input logic [3:0] en,
                       input string tag);
    logic [23:0] exp;
    req_valid = v; req_addr = a; way_en_idx = en;
    exp = model(v, a, en);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd2718));
    req_valid = 1'b1; req_addr = 32'h0804_0000; way_en_idx = 4'd0;
    repeat (2) @(negedge clk);
    check("R1 in reset", 24'h0);
    rst_n = 1'b1;
    check("R1 after release", 24'h0);

    apply(1, 32'h0802_0004, 4'd0, "R2 one-cycle R4 way1");
    apply(1, 32'h0800_0000, 4'd0, "R8 way0 refused R5");
    apply(1, 32'h0801_FFFF, 4'd0, "R8 top of way0 R5");
    apply(1, 32'h081F_FFFF, 4'd0, "R4 last byte way15");
    apply(1, 32'h0820_0000, 4'd0, "R3 just above window");
    apply(1, 32'h07FF_FFFF, 4'd0, "R3 just below window");
    apply(0, 32'h0806_0000, 4'd0, "R6 valid low");
    apply(1, 32'h081E_0010, 4'd15, "R8 index 15 refuses all R5");
    apply(1, 32'h0800_0100, 4'd15, "R8 index 15 way0");
    for (int e = 0; e < 15; e++) begin
      apply(1, {11'h040, 4'(e), 17'h00ABC}, 4'(e), "R8 boundary way refused");
      apply(1, {11'h040, 4'(e + 1), 17'h1F0F0}, 4'(e), "R8 next way open R4");
    end

    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic [3:0] en;
      v  = ($urandom % 8) != 0;
      en = 4'($urandom);
      a  = $urandom;
      if ($urandom % 4 != 0) a[31:21] = 11'h040;
      apply(v, a, en, "R2 R3 R4 R5 R6 R7 random");
    end

    req_valid = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule